// File: doc/BRIEF.md
# Framed Master-Transition Phase Detector

This block turns a recovered serial bit stream into a binary early/late phase decision for a bang-bang clock recovery loop. The stream is organised in frames of `FRAME_LEN` bits (20 by default). The line code places one guaranteed low-to-high step in every frame at a fixed slot. Each accepted beat carries two values. The first is the centre-of-bit data sample. The second is the sample taken on the boundary just before that bit. A slot counter picks out the one boundary sample that lands on the guaranteed step and drops the rest. That sample becomes the phase decision: 0 means the sampling clock is early, 1 means it is late. Data in the other slots is free and has no effect on the decision.

The decision is binary and has no hold state. It is registered, and it stays unchanged between master beats. A one-cycle strobe marks each new decision. The counter value is exported as the frame position. At start-up the transmitter sends a training pattern with a single rising step per frame. While training is enabled, the block treats that step as the master beat and realigns its counter to it. A lock flag reports a run of frames in which the master bit pair reads 0 then 1.

Input beats use a valid/ready handshake. `bit_ready` is held high at all times, so the block never applies back-pressure. A beat is taken on every clock edge where `bit_valid` is high. While `bit_valid` is low, the counter, the decision and the lock state do not move. The decision, the strobe, the position and the lock flag are plain status outputs with no handshake.

Top module: `anchor_edge_pd`

## Requirements
- R1: While reset is asserted, `late_o` is 0, `pd_strobe` is 0, `frame_pos` is 0 and `locked` is 0.
- R2: `bit_ready` is always 1. A beat is consumed only on a clock edge where `bit_valid` is 1. Without a beat, `frame_pos`, `late_o` and `locked` keep their values and `pd_strobe` is 0.
- R3: Outside a training realignment, each consumed beat advances `frame_pos` by one. The value wraps from `FRAME_LEN`-1 to 0. `frame_pos` is the slot the next beat will occupy.
- R4: With training off, a beat consumed while `frame_pos` equals `MASTER_SLOT` (default 1) is the master beat. In the next cycle `pd_strobe` is 1 for exactly one cycle, and `late_o` equals that beat's `edge_smp` (0 = early, 1 = late).
- R5: Boundary samples and data samples of all non-master beats leave `late_o` unchanged. `late_o` holds its value between strobes.
- R6: With training on, the master beat is a consumed beat with `mid_smp` = 1 whose previous consumed beat had `mid_smp` = 0. It strobes and updates `late_o` as in R4, and `frame_pos` becomes `MASTER_SLOT`+1 (mod `FRAME_LEN`). With training on, beats without such a rise never strobe, even in slot `MASTER_SLOT`.
- R7: After reset, the previous data sample counts as 1, so the first beat can never be a rise.
- R8: At each master beat the pair matches when the previous data sample is 0 and the current one is 1. `locked` rises in the same cycle as the strobe of the master beat that completes `lock_len` consecutive matches. A `lock_len` of 0 acts as 1.
- R9: A master beat whose pair does not match clears `locked` and the match run in the cycle of its strobe.
- R10: With training off, a 0-to-1 step in the data samples outside the master slot does not realign `frame_pos`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_en | input | 1 | Training realignment enable |
| lock_len | input | LOCK_W | Consecutive matching frames needed for lock |
| bit_valid | input | 1 | Beat present on `mid_smp`/`edge_smp` |
| bit_ready | output | 1 | Beat accepted; always 1 |
| mid_smp | input | 1 | Centre-of-bit data sample |
| edge_smp | input | 1 | Boundary sample taken before this bit |
| late_o | output | 1 | Registered phase decision, 1 = late, 0 = early |
| pd_strobe | output | 1 | One-cycle pulse when `late_o` is refreshed |
| frame_pos | output | POS_W | Slot index of the next beat |
| locked | output | 1 | Master pair matched for `lock_len` frames in a row |

## Verification
The hardest case to reach is the training realignment when the counter is in the wrong phase. The single rising step has to arrive while `frame_pos` sits far from the master slot, and a low-then-high pair must not pass through the master slot on the way. The stimulus reaches it by resetting with training on and sending a leading 1 (the reset value of the previous sample must suppress a false rise). Then comes a run of zeros that carries the counter past the master slot with no strobe, and then a single rise at slot 7. That rise must strobe and reload the counter. Frames with junk data in the free slots, a frame with a broken master pair, and a zero `lock_len` cover the lock run.

// File: rtl/ape_pkg.sv
package ape_pkg;
  // Slot index after `cur` in a frame of `len` bits.
  function automatic int unsigned slot_after(int unsigned cur, int unsigned len);
    return (cur + 1 >= len) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/ape_slot_ctr.sv
module ape_slot_ctr #(
  parameter int FRAME_LEN   = 20,
  parameter int MASTER_SLOT = 1,
  parameter int POS_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             train,
  input  logic             mid,
  output logic [POS_W-1:0] pos,
  output logic             sel,
  output logic             pair_ok
);
  localparam int RELOAD = ape_pkg::slot_after(MASTER_SLOT, FRAME_LEN);
  localparam logic [POS_W-1:0] LAST_SLOT = POS_W'(FRAME_LEN - 1);

  logic prev_mid;

  assign pair_ok = !prev_mid && mid;
  assign sel     = train ? pair_ok : (pos == POS_W'(MASTER_SLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      prev_mid <= 1'b1;
    end else if (adv) begin
      prev_mid <= mid;
      if (train && pair_ok)
        pos <= POS_W'(RELOAD);
      else if (pos == LAST_SLOT)
        pos <= '0;
      else
        pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/ape_decide.sv
module ape_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic edge_s,
  output logic late,
  output logic stb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      late <= 1'b0;
      stb  <= 1'b0;
    end else begin
      stb <= take;
      if (take) late <= edge_s;
    end
  end
endmodule

// File: rtl/ape_lock_mon.sv
module ape_lock_mon #(
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              match,
  input  logic [LOCK_W-1:0] lock_len,
  output logic              locked
);
  logic [LOCK_W-1:0] run;
  logic [LOCK_W-1:0] run_nxt;

  assign run_nxt = (run == '1) ? run : run + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (take) begin
      if (match) begin
        run    <= run_nxt;
        locked <= (run_nxt >= lock_len);
      end else begin
        run    <= '0;
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/anchor_edge_pd.sv
module anchor_edge_pd #(
  parameter int FRAME_LEN   = 20,
  parameter int MASTER_SLOT = 1,
  parameter int LOCK_W      = 4,
  localparam int POS_W      = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_en,
  input  logic [LOCK_W-1:0] lock_len,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              mid_smp,
  input  logic              edge_smp,
  output logic              late_o,
  output logic              pd_strobe,
  output logic [POS_W-1:0]  frame_pos,
  output logic              locked
);
  logic sel;
  logic pair_ok;
  logic take;

  assign bit_ready = 1'b1;
  assign take      = bit_valid && sel;

  ape_slot_ctr #(
    .FRAME_LEN  (FRAME_LEN),
    .MASTER_SLOT(MASTER_SLOT),
    .POS_W      (POS_W)
  ) i_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (bit_valid),
    .train  (train_en),
    .mid    (mid_smp),
    .pos    (frame_pos),
    .sel    (sel),
    .pair_ok(pair_ok)
  );

  ape_decide i_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .edge_s(edge_smp),
    .late  (late_o),
    .stb   (pd_strobe)
  );

  ape_lock_mon #(.LOCK_W(LOCK_W)) i_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .match   (pair_ok),
    .lock_len(lock_len),
    .locked  (locked)
  );
endmodule

// File: rtl/ape_checker.sv
module ape_checker #(
  parameter int FRAME_LEN   = 20,
  parameter int MASTER_SLOT = 1,
  parameter int POS_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             train_en,
  input logic             bit_valid,
  input logic             edge_smp,
  input logic             late_o,
  input logic             pd_strobe,
  input logic [POS_W-1:0] frame_pos,
  input logic             locked
);
  p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pos < POS_W'(FRAME_LEN));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(frame_pos) && !pd_strobe);

  p_strobe_needs_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pd_strobe |-> $past(bit_valid));

  p_strobe_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pd_strobe |-> late_o == $past(edge_smp));

  p_master_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !train_en && frame_pos == POS_W'(MASTER_SLOT)) |=> pd_strobe);

  p_decision_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_strobe |-> $stable(late_o));

  p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> pd_strobe);

  p_lock_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> pd_strobe);
endmodule

bind anchor_edge_pd ape_checker #(
  .FRAME_LEN  (FRAME_LEN),
  .MASTER_SLOT(MASTER_SLOT),
  .POS_W      (POS_W)
) i_ape_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .train_en (train_en),
  .bit_valid(bit_valid),
  .edge_smp (edge_smp),
  .late_o   (late_o),
  .pd_strobe(pd_strobe),
  .frame_pos(frame_pos),
  .locked   (locked)
);

// File: tb/test_anchor_edge_pd.sv
module test_anchor_edge_pd;
  localparam int PERIOD = 10;
  localparam int NVEC   = 6;
  // {valid, mid, edge, exp_strobe, exp_late, exp_pos[4:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_0_1_0_0_00001,
    10'b1_1_0_1_0_00010,
    10'b0_0_1_0_0_00010,
    10'b1_0_1_0_0_00011,
    10'b1_1_1_0_0_00100,
    10'b1_0_0_0_0_00101
  };

  logic       clk = 1'b0;
  logic       rst_n, train_en, bit_valid, bit_ready, mid_smp, edge_smp;
  logic [3:0] lock_len;
  logic       late_o, pd_strobe, locked;
  logic [4:0] frame_pos;
  int checks = 0;
  int errors = 0;
  logic exp_late;

  anchor_edge_pd i_anchor_edge_pd (
    .clk(clk), .rst_n(rst_n), .train_en(train_en), .lock_len(lock_len),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .mid_smp(mid_smp),
    .edge_smp(edge_smp), .late_o(late_o), .pd_strobe(pd_strobe),
    .frame_pos(frame_pos), .locked(locked)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic m, input logic e);
    bit_valid = v; mid_smp = m; edge_smp = e;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_valid = 1'b0; mid_smp = 1'b0; edge_smp = 1'b0;
    repeat (2) @(posedge clk);
    #(PERIOD/4);
    chk(late_o == 1'b0 && pd_strobe == 1'b0, "R1 late/strobe", {late_o, pd_strobe}, 0);
    chk(frame_pos == 5'd0 && locked == 1'b0, "R1 pos/locked", {locked, frame_pos}, 0);
    chk(bit_ready == 1'b1, "R2 ready", bit_ready, 1);
    rst_n = 1'b1;
    exp_late = 1'b0;
  endtask

  // One frame starting at slot 0; junk in free slots.
  task automatic send_frame(input logic good, input logic e, input logic exp_lock);
    for (int s = 0; s < 20; s++) begin
      logic m, ed;
      m  = (s == 0) ? !good : (s == 1) ? 1'b1 : (s[0] ^ s[1]);
      ed = (s == 1) ? e : (s[1] ^ s[3]);
      step(1'b1, m, ed);
      if (s == 1) exp_late = e;
      chk(pd_strobe == (s == 1), "R4 strobe", pd_strobe, (s == 1));
      chk(late_o == exp_late, "R5 late hold", late_o, exp_late);
      chk(frame_pos == 5'((s + 1) % 20), "R3 pos", frame_pos, (s + 1) % 20);
    end
    chk(locked == exp_lock, exp_lock ? "R8 locked" : "R9 unlocked", locked, exp_lock);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    train_en = 1'b0; lock_len = 4'd3;
    #(PERIOD/4);
    do_reset();

    // Table walk: slot advance, idle beat (R2), master pick, R10 rise ignored
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][9], VEC[i][8], VEC[i][7]);
      chk(pd_strobe == VEC[i][6], "R4 table strobe", pd_strobe, VEC[i][6]);
      chk(late_o == VEC[i][5], "R5 table late", late_o, VEC[i][5]);
      chk(frame_pos == VEC[i][4:0], "R10 table pos", frame_pos, VEC[i][4:0]);
    end

    // Lock run, mismatch, zero lock length
    do_reset();
    send_frame(1'b1, 1'b1, 1'b0);
    send_frame(1'b1, 1'b0, 1'b0);
    send_frame(1'b1, 1'b1, 1'b1);
    send_frame(1'b0, 1'b0, 1'b0);
    lock_len = 4'd0;
    send_frame(1'b1, 1'b1, 1'b1);

    // Training realignment from a misaligned counter
    lock_len = 4'd3;
    train_en = 1'b1;
    do_reset();
    step(1'b1, 1'b1, 1'b1);
    chk(pd_strobe == 1'b0, "R7 no rise after reset", pd_strobe, 0);
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, 1'b1);
      chk(pd_strobe == 1'b0, "R6 no strobe without rise", pd_strobe, 0);
      chk(frame_pos == 5'(k + 2), "R3 train pos", frame_pos, k + 2);
    end
    step(1'b1, 1'b1, 1'b1);
    chk(pd_strobe == 1'b1 && late_o == 1'b1, "R6 rise strobe", {pd_strobe, late_o}, 3);
    chk(frame_pos == 5'd2, "R6 reload pos", frame_pos, 2);
    train_en = 1'b0;
    for (int k = 2; k < 20; k++) begin
      step(1'b1, 1'b1, 1'b0);
      chk(pd_strobe == 1'b0 && late_o == 1'b1, "R5 after train", {pd_strobe, late_o}, 1);
    end
    chk(frame_pos == 5'd0, "R3 wrap", frame_pos, 0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    chk(pd_strobe == 1'b1 && late_o == 1'b0, "R4 aligned master", {pd_strobe, late_o}, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule